// File: doc/BRIEF.md
# Eight-bit Arithmetic and Logic Unit

This block is a purely combinational 8-bit arithmetic and logic unit for a small register machine. It takes two 8-bit operands, a 4-bit signed immediate and a 4-bit operation code. From these it computes an 8-bit result and three status flags: zero, sign and overflow. A sequencer elsewhere combines the flags to decide branch comparisons.

The block covers the following operations:

- add and subtract
- the four bitwise operations
- two's-complement negation
- addition of a sign-extended immediate
- three kinds of shift, with the amount taken from operand B
- the low byte of an 8x8 multiply
- pass-through of operand A

The shift amount is treated as a signed byte, so the block defines the results for amounts of eight or more and for negative amounts. Operation codes that are not listed return operand A.

Top module: `alu8`

## Requirements
- R1: Code 1 (add) returns (A+B) mod 256 and code 2 (subtract) returns (A-B) mod 256. v is 1 exactly when the signed result overflows.
- R2: Code 3 returns A|B, code 4 A&B, code 5 ~A and code 6 A^B, each with v=0.
- R3: Code 7 (negate) returns (0-A) mod 256. v=1 only for A=0x80.
- R4: Code 8 (increment) returns A plus the immediate sign-extended to 8 bits, so immediates 8..15 act as -8..-1. v flags signed overflow.
- R5: Code 9 (shift left) and code 10 (logical shift right) fill with zeros. A non-negative amount B of 8 or more gives 0x00.
- R6: Code 11 (arithmetic shift right) fills with A bit 7. A non-negative amount of 8 or more gives 0xFF when A is negative and 0x00 otherwise.
- R7: For codes 9, 10 and 11, a negative amount (B bit 7 set) returns A unchanged.
- R8: Code 12 (multiply) returns the low 8 bits of A*B with v=0.
- R9: z is 1 exactly when the result is 0x00, and s equals result bit 7, for every code.
- R10: v is 0 for every code except 1, 2, 7 and 8.
- R11: Code 0 and the unused codes 13, 14 and 15 return A unchanged with v=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| a | input | 8 | First operand; also the value that is shifted or negated |
| b | input | 8 | Second operand; signed shift amount for shifts |
| imm | input | 4 | Signed immediate for increment |
| res | output | 8 | Result |
| z | output | 1 | Result is zero |
| s | output | 1 | Result bit 7 |
| v | output | 1 | Signed overflow of add, subtract, negate or increment |

## Verification
The block holds no registers, so every result and flag settles within the cycle in which its inputs change. The driver applies each vector one time unit after a rising edge. The monitor compares result, z, s and v at the next falling edge, half a period later. One expected entry is queued per vector and popped at that falling edge, so each comparison lands on the vector it belongs to.

// File: rtl/alu8.sv
module alu8 #(
  parameter int W  = 8,
  parameter int IW = 4
) (
  input  logic [3:0]    op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [IW-1:0] imm,
  output logic [W-1:0]  res,
  output logic          z,
  output logic          s,
  output logic          v
);
  localparam int SW = $clog2(W);

  localparam logic [3:0] OP_PASS = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2,
                         OP_OR   = 4'd3, OP_AND = 4'd4, OP_NOT = 4'd5,
                         OP_XOR  = 4'd6, OP_NEG = 4'd7, OP_INC = 4'd8,
                         OP_SHL  = 4'd9, OP_SHR = 4'd10, OP_SAR = 4'd11,
                         OP_MUL  = 4'd12;

  logic [W-1:0]   imm_x, addend, sum;
  logic           sub_mode;
  logic [W-1:0]   lhs;
  logic           amt_neg, amt_big;
  logic [SW-1:0]  amt;
  logic [W-1:0]   shl_r, shr_r, sar_r;
  logic [2*W-1:0] prod;
  logic           arith;

  assign imm_x    = {{(W-IW){imm[IW-1]}}, imm};
  assign sub_mode = (op == OP_SUB) || (op == OP_NEG);
  assign lhs      = (op == OP_NEG) ? '0 : a;
  assign addend   = (op == OP_NEG) ? ~a : (op == OP_SUB) ? ~b :
                    (op == OP_INC) ? imm_x : b;
  assign sum      = lhs + addend + {{(W-1){1'b0}}, sub_mode};
  assign arith    = (op == OP_ADD) || (op == OP_SUB) || (op == OP_NEG) || (op == OP_INC);

  assign amt_neg = b[W-1];
  assign amt_big = |b[W-2:SW];
  assign amt     = b[SW-1:0];
  assign shl_r   = amt_neg ? a : amt_big ? '0 : (a << amt);
  assign shr_r   = amt_neg ? a : amt_big ? '0 : (a >> amt);
  assign sar_r   = amt_neg ? a : amt_big ? {W{a[W-1]}} : W'($signed(a) >>> amt);
  assign prod    = a * b;

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_NEG, OP_INC: res = sum;
      OP_OR:  res = a | b;
      OP_AND: res = a & b;
      OP_NOT: res = ~a;
      OP_XOR: res = a ^ b;
      OP_SHL: res = shl_r;
      OP_SHR: res = shr_r;
      OP_SAR: res = sar_r;
      OP_MUL: res = prod[W-1:0];
      default: res = a;
    endcase
  end

  assign v = arith && (lhs[W-1] == addend[W-1]) && (sum[W-1] != lhs[W-1]);
  assign z = (res == '0);
  assign s = res[W-1];

  always_comb begin
    if (op == OP_ADD) p_add_inverse_r1: assert (W'(res - b) == a);
    if (op == OP_SUB) p_sub_inverse_r1: assert (W'(res + b) == a);
    if (op == OP_NOT) p_not_complement_r2: assert ((res ^ a) == {W{1'b1}});
    if (op == OP_XOR) p_xor_inverse_r2: assert ((res ^ b) == a);
    if (op == OP_NEG) p_neg_sum_zero_r3: assert (W'(res + a) == '0);
    if (op == OP_SHL && !b[W-1] && b >= W) p_shl_big_r5: assert (res == '0);
    if ((op == OP_SHL || op == OP_SHR || op == OP_SAR) && b[W-1])
      p_negamt_keep_r7: assert (res == a);
    if (!arith) p_no_overflow_r10: assert (!v);
    if (op == OP_PASS || op > OP_MUL) p_pass_r11: assert (res == a);
  end
endmodule

// File: tb/alu8_tb.sv
module alu8_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic [3:0] imm = '0;
  logic [7:0] res;
  logic z, s, v;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [7:0] exp_r_q[$];
  logic       exp_v_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  alu8 u_dut (.op(op), .a(a), .b(b), .imm(imm), .res(res), .z(z), .s(s), .v(v));

  task automatic chk(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [7:0] ai, input logic [7:0] bi,
                       input logic [3:0] ii, input logic [7:0] er, input logic ev, input string tag);
    @(posedge clk);
    #1;
    op = o; a = ai; b = bi; imm = ii;
    exp_r_q.push_back(er);
    exp_v_q.push_back(ev);
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_r_q.size() > 0) begin
        logic [7:0] er;
        logic ev;
        string t;
        er = exp_r_q.pop_front();
        ev = exp_v_q.pop_front();
        t  = tag_q.pop_front();
        chk(t, "res", res, er);
        chk(t, "v", v, ev);
        chk({t, "/R9"}, "z", z, er == 8'h00);
        chk({t, "/R9"}, "s", s, er[7]);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(4'd0, 8'h00, 8'h00, 4'h0, 8'h00, 1'b0, "R11 idle");
    drive(4'd1, 8'h7F, 8'h01, 4'h0, 8'h80, 1'b1, "R1 add ovf");
    drive(4'd1, 8'hFF, 8'h01, 4'h0, 8'h00, 1'b0, "R1 add wrap");
    drive(4'd1, 8'h80, 8'h80, 4'h0, 8'h00, 1'b1, "R1 add negovf");
    drive(4'd2, 8'h05, 8'h07, 4'h0, 8'hFE, 1'b0, "R1 sub neg");
    drive(4'd2, 8'h80, 8'h01, 4'h0, 8'h7F, 1'b1, "R1 sub ovf");
    drive(4'd2, 8'h7F, 8'hFF, 4'h0, 8'h80, 1'b1, "R1 sub ovf2");
    drive(4'd3, 8'hF0, 8'h0F, 4'h0, 8'hFF, 1'b0, "R2 or");
    drive(4'd4, 8'hF0, 8'h3C, 4'h0, 8'h30, 1'b0, "R2 and");
    drive(4'd5, 8'h5A, 8'h00, 4'h0, 8'hA5, 1'b0, "R2 not");
    drive(4'd6, 8'hFF, 8'h0F, 4'h0, 8'hF0, 1'b0, "R2 xor");
    drive(4'd7, 8'h01, 8'h00, 4'h0, 8'hFF, 1'b0, "R3 neg");
    drive(4'd7, 8'h80, 8'h00, 4'h0, 8'h80, 1'b1, "R3 neg min");
    drive(4'd7, 8'h00, 8'h00, 4'h0, 8'h00, 1'b0, "R3 neg zero");
    drive(4'd8, 8'h10, 8'h00, 4'h7, 8'h17, 1'b0, "R4 inc pos");
    drive(4'd8, 8'h10, 8'h00, 4'hF, 8'h0F, 1'b0, "R4 inc minus1");
    drive(4'd8, 8'h7F, 8'h00, 4'h1, 8'h80, 1'b1, "R4 inc ovf");
    drive(4'd8, 8'h80, 8'h00, 4'h8, 8'h78, 1'b1, "R4 inc negovf");
    drive(4'd8, 8'h05, 8'h00, 4'h8, 8'hFD, 1'b0, "R4 inc minus8");
    drive(4'd9, 8'h81, 8'h01, 4'h0, 8'h02, 1'b0, "R5 shl1");
    drive(4'd9, 8'h81, 8'h07, 4'h0, 8'h80, 1'b0, "R5 shl7");
    drive(4'd9, 8'h81, 8'h08, 4'h0, 8'h00, 1'b0, "R5 shl8");
    drive(4'd9, 8'hFF, 8'h7F, 4'h0, 8'h00, 1'b0, "R5 shl127");
    drive(4'd10, 8'h81, 8'h01, 4'h0, 8'h40, 1'b0, "R5 shr1");
    drive(4'd10, 8'h81, 8'h07, 4'h0, 8'h01, 1'b0, "R5 shr7");
    drive(4'd10, 8'h81, 8'h08, 4'h0, 8'h00, 1'b0, "R5 shr8");
    drive(4'd11, 8'h80, 8'h03, 4'h0, 8'hF0, 1'b0, "R6 sar neg");
    drive(4'd11, 8'h40, 8'h02, 4'h0, 8'h10, 1'b0, "R6 sar pos");
    drive(4'd11, 8'h80, 8'h09, 4'h0, 8'hFF, 1'b0, "R6 sar big neg");
    drive(4'd11, 8'h7F, 8'h08, 4'h0, 8'h00, 1'b0, "R6 sar big pos");
    drive(4'd9, 8'h81, 8'hFF, 4'h0, 8'h81, 1'b0, "R7 shl negamt");
    drive(4'd10, 8'h81, 8'h80, 4'h0, 8'h81, 1'b0, "R7 shr negamt");
    drive(4'd11, 8'h81, 8'hF8, 4'h0, 8'h81, 1'b0, "R7 sar negamt");
    drive(4'd12, 8'h10, 8'h10, 4'h0, 8'h00, 1'b0, "R8 mul wrap");
    drive(4'd12, 8'h0F, 8'h11, 4'h0, 8'hFF, 1'b0, "R8 mul");
    drive(4'd12, 8'hFF, 8'hFF, 4'h0, 8'h01, 1'b0, "R8 mul neg");
    drive(4'd13, 8'hC3, 8'h7F, 4'h0, 8'hC3, 1'b0, "R11 code13");
    drive(4'd14, 8'hC3, 8'h80, 4'h0, 8'hC3, 1'b0, "R11 code14");
    drive(4'd15, 8'hC3, 8'hFF, 4'h0, 8'hC3, 1'b0, "R11 code15");
    drive(4'd0, 8'h99, 8'h01, 4'h0, 8'h99, 1'b0, "R11 pass");
    drive(4'd3, 8'h80, 8'h80, 4'h0, 8'h80, 1'b0, "R10 or no v");
    wait (exp_r_q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule